// File: doc/BRIEF.md
# E1 National-Bit Receive Pin Extractor

This block sits in the recovered receive clock domain, ahead of any slip buffer. It takes the decoded 2.048 Mbit/s receive stream and puts it on a data-link output pin. Beside the data it drives a strobe that marks the timeslot-zero national bits (Sa4 to Sa8) chosen by software, and only in frames that do not carry the alignment word. An external frame-alignment circuit supplies a lock flag and a frame-start marker. A quarter-cell enable, running at four times the bit rate, places the strobe edges inside each cell. Because the data-link bits never enter the elastic store, a receive slip cannot drop or repeat them.

Each Sa position has a two-bit select field, and only the code 2'b01 routes that position to the pins. A mode input picks the strobe form. In gapped-clock form the strobe is a positive pulse over the second half of a selected cell. In enable form the strobe is low for the whole of a selected cell and high at all other times.

A frame-phase state machine tracks the frame. ST_UNLOCKED holds while lock is absent. ST_ALIGN covers the frame start up to the alignment-indicator bit. ST_NAT marks a non-alignment frame through the end of its Sa bits. ST_REST covers the rest of the frame and every alignment frame. The transitions are: any state to ST_UNLOCKED when lock is low at a quarter tick; any state to ST_ALIGN on entering bit 0 while locked; ST_ALIGN to ST_NAT or ST_REST on entering the indicator bit, according to that bit's value; ST_NAT to ST_REST on entering the first bit after Sa8.

Top module: `e1_sa_rx_tap`

## Requirements
- R1: While reset is asserted, and after its release until the first quarter tick, dl_data and dl_strobe are both 0.
- R2: On each quarter tick that opens a bit cell, dl_data takes rx_bit, and it holds that value for all four quarters of the cell. Outputs change only on cycles that follow a q_en tick.
- R3: In gapped-clock mode (strobe_en_mode=0), dl_strobe is low in quarters 0 and 1 of a selected cell and high in quarters 2 and 3. It therefore rises at mid-cell and falls at the next cell boundary.
- R4: In enable mode (strobe_en_mode=1), dl_strobe is low in all four quarters of a selected cell and high in every other cell.
- R5: Sa(4+i) sits at frame bit position 3+i, counting from 0. It is selected only when sa_sel[2i+1:2i] equals 2'b01; the codes 00, 10 and 11 select nothing.
- R6: Sa cells are selected only in frames whose bit at position 1 (the second bit of timeslot zero) is 1.
- R7: While align_lock is low, no cell is selected. Once lock returns, selection resumes only from the next frame start.
- R8: frame_sync asserted with a q_en tick restarts the position at bit 0, quarter 0, even in the middle of a frame.
- R9: In gapped-clock mode, dl_strobe stays low in every cell that is not selected.
- R10: Without frame_sync, the position wraps from bit FRAME_BITS-1, quarter 3 to bit 0, quarter 0, and selection continues in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_en | input | 1 | Quarter-cell tick, four per bit cell |
| frame_sync | input | 1 | With q_en: this tick opens bit 0 of a frame |
| align_lock | input | 1 | Frame alignment achieved |
| rx_bit | input | 1 | Decoded receive bit, valid at the cell-opening tick |
| sa_sel | input | 2*NUM_SA | Two-bit select per Sa position, Sa4 in the lowest field |
| strobe_en_mode | input | 1 | 0 = gapped clock, 1 = active-low enable |
| dl_data | output | 1 | Receive stream to the data-link pin |
| dl_strobe | output | 1 | Data-link clock or enable |

## Verification
The bench builds the block with FRAME_BITS set to 16 and all other parameters at their defaults. The short frame keeps each frame to 64 quarter ticks. That puts natural frame wrap, a mid-frame restart, lock loss and recovery, and every select pattern in the vector table within a few thousand cycles. The default quarter count of four leaves the mid-cell rising edge and the boundary falling edge at the positions the requirements give.

// File: rtl/e1sa_pkg.sv
package e1sa_pkg;

    typedef enum logic [1:0] {
        ST_UNLOCKED = 2'd0,
        ST_ALIGN    = 2'd1,
        ST_NAT      = 2'd2,
        ST_REST     = 2'd3
    } tap_state_t;

    localparam logic [1:0] SA_PIN_CODE = 2'b01;

endpackage

// File: rtl/e1sa_timebase.sv
module e1sa_timebase #(
    parameter int FRAME_BITS = 256,
    parameter int Q_PER_BIT  = 4,
    localparam int QW = $clog2(Q_PER_BIT),
    localparam int BW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          q_en,
    input  logic          frame_sync,
    output logic [QW-1:0] q_nxt,
    output logic [BW-1:0] b_nxt
);
    localparam logic [QW-1:0] Q_LAST = QW'(Q_PER_BIT - 1);
    localparam logic [BW-1:0] B_LAST = BW'(FRAME_BITS - 1);

    logic [QW-1:0] qcnt;
    logic [BW-1:0] bcnt;

    always_comb begin
        q_nxt = qcnt;
        b_nxt = bcnt;
        if (frame_sync) begin
            q_nxt = '0;
            b_nxt = '0;
        end else if (qcnt == Q_LAST) begin
            q_nxt = '0;
            b_nxt = (bcnt == B_LAST) ? '0 : bcnt + 1'b1;
        end else begin
            q_nxt = qcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qcnt <= Q_LAST;
            bcnt <= B_LAST;
        end else if (q_en) begin
            qcnt <= q_nxt;
            bcnt <= b_nxt;
        end
    end

endmodule

// File: rtl/e1sa_frame_fsm.sv
module e1sa_frame_fsm
    import e1sa_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int Q_PER_BIT  = 4,
    parameter int NUM_SA     = 5,
    parameter int FIRST_SA   = 3,
    parameter int NFAS_POS   = 1,
    localparam int QW = $clog2(Q_PER_BIT),
    localparam int BW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          q_en,
    input  logic          align_lock,
    input  logic          rx_bit,
    input  logic [QW-1:0] q_nxt,
    input  logic [BW-1:0] b_nxt,
    output tap_state_t    st_nxt
);
    localparam logic [BW-1:0] IND_POS = BW'(NFAS_POS);
    localparam logic [BW-1:0] SA_END  = BW'(FIRST_SA + NUM_SA);

    tap_state_t state;
    logic       cell_open;

    assign cell_open = q_en && (q_nxt == '0);

    always_comb begin
        st_nxt = state;
        if (q_en && !align_lock) begin
            st_nxt = ST_UNLOCKED;
        end else if (cell_open && (b_nxt == '0)) begin
            st_nxt = ST_ALIGN;
        end else if (cell_open) begin
            unique case (state)
                ST_UNLOCKED: st_nxt = ST_UNLOCKED;
                ST_ALIGN:    if (b_nxt == IND_POS) st_nxt = rx_bit ? ST_NAT : ST_REST;
                ST_NAT:      if (b_nxt == SA_END) st_nxt = ST_REST;
                ST_REST:     st_nxt = ST_REST;
                default:     st_nxt = ST_UNLOCKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_UNLOCKED;
        else        state <= st_nxt;
    end

endmodule

// File: rtl/e1sa_pin_out.sv
module e1sa_pin_out
    import e1sa_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int Q_PER_BIT  = 4,
    parameter int NUM_SA     = 5,
    parameter int FIRST_SA   = 3,
    localparam int QW = $clog2(Q_PER_BIT),
    localparam int BW = $clog2(FRAME_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                q_en,
    input  logic                rx_bit,
    input  logic [QW-1:0]       q_nxt,
    input  logic [BW-1:0]       b_nxt,
    input  tap_state_t          st_nxt,
    input  logic [2*NUM_SA-1:0] sa_sel,
    input  logic                strobe_en_mode,
    output logic                dl_data,
    output logic                dl_strobe
);
    localparam logic [QW-1:0] HALF_Q = QW'(Q_PER_BIT / 2);

    logic [NUM_SA-1:0] sa_hit;
    logic              sel_cell;
    logic              late_half;

    for (genvar gi = 0; gi < NUM_SA; gi++) begin : g_sa
        localparam logic [BW-1:0] POS = BW'(FIRST_SA + gi);
        assign sa_hit[gi] = (b_nxt == POS) && (sa_sel[2*gi +: 2] == SA_PIN_CODE);
    end

    assign sel_cell  = (st_nxt == ST_NAT) && (|sa_hit);
    assign late_half = (q_nxt >= HALF_Q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dl_data   <= 1'b0;
            dl_strobe <= 1'b0;
        end else if (q_en) begin
            if (q_nxt == '0) dl_data <= rx_bit;
            dl_strobe <= strobe_en_mode ? !sel_cell : (sel_cell && late_half);
        end
    end

endmodule

// File: rtl/e1_sa_rx_tap.sv
module e1_sa_rx_tap
    import e1sa_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int Q_PER_BIT  = 4,
    parameter int NUM_SA     = 5,
    parameter int FIRST_SA   = 3,
    parameter int NFAS_POS   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                q_en,
    input  logic                frame_sync,
    input  logic                align_lock,
    input  logic                rx_bit,
    input  logic [2*NUM_SA-1:0] sa_sel,
    input  logic                strobe_en_mode,
    output logic                dl_data,
    output logic                dl_strobe
);
    localparam int QW = $clog2(Q_PER_BIT);
    localparam int BW = $clog2(FRAME_BITS);

    logic [QW-1:0] q_nxt;
    logic [BW-1:0] b_nxt;
    tap_state_t    st_nxt;

    e1sa_timebase #(
        .FRAME_BITS(FRAME_BITS),
        .Q_PER_BIT (Q_PER_BIT)
    ) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_en      (q_en),
        .frame_sync(frame_sync),
        .q_nxt     (q_nxt),
        .b_nxt     (b_nxt)
    );

    e1sa_frame_fsm #(
        .FRAME_BITS(FRAME_BITS),
        .Q_PER_BIT (Q_PER_BIT),
        .NUM_SA    (NUM_SA),
        .FIRST_SA  (FIRST_SA),
        .NFAS_POS  (NFAS_POS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_en      (q_en),
        .align_lock(align_lock),
        .rx_bit    (rx_bit),
        .q_nxt     (q_nxt),
        .b_nxt     (b_nxt),
        .st_nxt    (st_nxt)
    );

    e1sa_pin_out #(
        .FRAME_BITS(FRAME_BITS),
        .Q_PER_BIT (Q_PER_BIT),
        .NUM_SA    (NUM_SA),
        .FIRST_SA  (FIRST_SA)
    ) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .q_en          (q_en),
        .rx_bit        (rx_bit),
        .q_nxt         (q_nxt),
        .b_nxt         (b_nxt),
        .st_nxt        (st_nxt),
        .sa_sel        (sa_sel),
        .strobe_en_mode(strobe_en_mode),
        .dl_data       (dl_data),
        .dl_strobe     (dl_strobe)
    );

endmodule

// File: rtl/e1_sa_rx_tap_chk.sv
module e1_sa_rx_tap_chk #(
    parameter int FRAME_BITS = 256,
    parameter int Q_PER_BIT  = 4,
    parameter int NUM_SA     = 5,
    parameter int FIRST_SA   = 3,
    parameter int NFAS_POS   = 1
) (
    input logic clk,
    input logic rst_n,
    input logic q_en,
    input logic frame_sync,
    input logic align_lock,
    input logic rx_bit,
    input logic strobe_en_mode,
    input logic dl_data,
    input logic dl_strobe
);
    localparam int QW = $clog2(Q_PER_BIT);
    localparam int BW = $clog2(FRAME_BITS);
    localparam logic [QW-1:0] Q_LAST = QW'(Q_PER_BIT - 1);
    localparam logic [BW-1:0] B_LAST = BW'(FRAME_BITS - 1);
    localparam logic [QW-1:0] HALF_Q = QW'(Q_PER_BIT / 2);
    localparam logic [BW-1:0] SA_LO  = BW'(FIRST_SA);
    localparam logic [BW-1:0] SA_HI  = BW'(FIRST_SA + NUM_SA - 1);
    localparam logic [BW-1:0] IND    = BW'(NFAS_POS);

    logic [QW-1:0] qc, qn;
    logic [BW-1:0] bc, bn;
    logic          nfas_seen;

    always_comb begin
        qn = qc + 1'b1;
        bn = bc;
        if (frame_sync) begin
            qn = '0;
            bn = '0;
        end else if (qc == Q_LAST) begin
            qn = '0;
            bn = (bc == B_LAST) ? '0 : bc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qc        <= Q_LAST;
            bc        <= B_LAST;
            nfas_seen <= 1'b0;
        end else if (q_en) begin
            qc <= qn;
            bc <= bn;
            if (qn == '0 && bn == '0) nfas_seen <= 1'b0;
            else if (qn == '0 && bn == IND) nfas_seen <= rx_bit;
        end
    end

    // R2: outputs move only after a quarter tick
    assert_quiet_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !q_en |=> ($stable(dl_data) && $stable(dl_strobe)));

    // R3: gapped clock rises at mid-cell
    assert_rise_mid_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dl_strobe) && !strobe_en_mode && !$past(strobe_en_mode)) |-> (qc == HALF_Q));

    // R3: gapped clock falls at the cell boundary
    assert_fall_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dl_strobe) && !strobe_en_mode && !$past(strobe_en_mode)) |-> (qc == '0));

    // R5: pulses only inside the Sa window
    assert_pulse_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dl_strobe) && !strobe_en_mode && !$past(strobe_en_mode)) |-> (bc >= SA_LO && bc <= SA_HI));

    // R6: pulses only in non-alignment frames
    assert_pulse_nfas_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dl_strobe) && !strobe_en_mode && !$past(strobe_en_mode)) |-> nfas_seen);

    // R7: no gapped clock without lock
    assert_silent_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_en && !align_lock && !strobe_en_mode) |=> !dl_strobe);

endmodule

bind e1_sa_rx_tap e1_sa_rx_tap_chk #(
    .FRAME_BITS(FRAME_BITS),
    .Q_PER_BIT (Q_PER_BIT),
    .NUM_SA    (NUM_SA),
    .FIRST_SA  (FIRST_SA),
    .NFAS_POS  (NFAS_POS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .q_en          (q_en),
    .frame_sync    (frame_sync),
    .align_lock    (align_lock),
    .rx_bit        (rx_bit),
    .strobe_en_mode(strobe_en_mode),
    .dl_data       (dl_data),
    .dl_strobe     (dl_strobe)
);

// File: tb/e1_sa_rx_tap_test.sv
module e1_sa_rx_tap_test;
    localparam int CLK_PERIOD = 10;
    localparam int FB = 16;
    localparam int NV = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       q_en = 1'b0;
    logic       frame_sync = 1'b0;
    logic       align_lock = 1'b0;
    logic       rx_bit = 1'b0;
    logic [9:0] sa_sel = '0;
    logic       strobe_en_mode = 1'b0;
    logic       dl_data;
    logic       dl_strobe;

    int checks = 0;
    int fails = 0;
    logic st [FB][4];
    logic dd [FB][4];

    always #(CLK_PERIOD/2) clk = ~clk;

    e1_sa_rx_tap #(.FRAME_BITS(FB)) uut (
        .clk(clk), .rst_n(rst_n), .q_en(q_en), .frame_sync(frame_sync),
        .align_lock(align_lock), .rx_bit(rx_bit), .sa_sel(sa_sel),
        .strobe_en_mode(strobe_en_mode), .dl_data(dl_data), .dl_strobe(dl_strobe)
    );

    // {mode, sa_sel[9:0], nfas bit, expected Sa mask (bit0 = Sa4)}
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 10'b01_01_01_01_01, 1'b1, 5'b11111},
        {1'b0, 10'b01_01_01_01_01, 1'b0, 5'b00000},
        {1'b0, 10'b00_00_00_00_01, 1'b1, 5'b00001},
        {1'b0, 10'b01_00_00_00_00, 1'b1, 5'b10000},
        {1'b0, 10'b11_10_01_00_01, 1'b1, 5'b00101},
        {1'b1, 10'b01_01_01_01_01, 1'b1, 5'b11111},
        {1'b1, 10'b01_11_00_01_10, 1'b1, 5'b10010},
        {1'b1, 10'b01_01_01_01_01, 1'b0, 5'b00000},
        {1'b0, 10'b00_00_00_00_00, 1'b1, 5'b00000},
        {1'b1, 10'b10_10_10_10_10, 1'b1, 5'b00000}
    };

    task automatic quarter(input logic b, input logic fs, input logic lk,
                           output logic s, output logic d);
        @(negedge clk);
        q_en = 1'b1; rx_bit = b; frame_sync = fs; align_lock = lk;
        @(negedge clk);
        q_en = 1'b0; frame_sync = 1'b0;
        s = dl_strobe; d = dl_data;
    endtask

    task automatic run_frame(input logic [FB-1:0] fb, input logic fs,
                             input logic [FB-1:0] lk, input int ncells);
        for (int c = 0; c < ncells; c++)
            for (int q = 0; q < 4; q++)
                quarter(fb[c], fs && c == 0 && q == 0, lk[c], st[c][q], dd[c][q]);
    endtask

    task automatic check_frame(input logic [FB-1:0] fb, input logic m,
                               input logic [4:0] mask, input string tag);
        for (int c = 0; c < FB; c++) begin
            logic sel;
            logic [3:0] got, exp, gd, ed;
            sel = (c >= 3 && c <= 7) ? mask[c-3] : 1'b0;
            for (int q = 0; q < 4; q++) begin
                got[q] = st[c][q];
                exp[q] = m ? !sel : (sel && q >= 2);
                gd[q]  = dd[c][q];
                ed[q]  = fb[c];
            end
            checks++;
            if (got !== exp) begin
                fails++;
                $display("FAIL %s %s cell %0d strobe q3..q0 got %b expected %b", tag,
                         m ? "R4" : (sel ? "R3" : "R9"), c, got, exp);
            end
            checks++;
            if (gd !== ed) begin
                fails++;
                $display("FAIL %s R2 cell %0d data q3..q0 got %b expected %b", tag, c, gd, ed);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [FB-1:0] fb;
        repeat (3) @(negedge clk);
        checks++;
        if (dl_data !== 1'b0 || dl_strobe !== 1'b0) begin
            fails++;
            $display("FAIL R1 in reset got %b%b expected 00", dl_data, dl_strobe);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        checks++;
        if (dl_data !== 1'b0 || dl_strobe !== 1'b0) begin
            fails++;
            $display("FAIL R1 after release got %b%b expected 00", dl_data, dl_strobe);
        end

        // vector table: R5 and R6 across both strobe forms
        for (int i = 0; i < NV; i++) begin
            strobe_en_mode = VEC[i][16];
            sa_sel = VEC[i][15:6];
            fb = 16'h5A3C ^ (16'(i) * 16'h0F0F);
            fb[1] = VEC[i][5];
            run_frame(fb, 1'b1, '1, FB);
            check_frame(fb, VEC[i][16], VEC[i][4:0], $sformatf("R5 R6 vec%0d", i));
        end

        // R10: natural wrap without frame_sync
        strobe_en_mode = 1'b0;
        sa_sel = 10'b01_01_01_01_01;
        fb = 16'hC3A6;
        run_frame(fb, 1'b0, '1, FB);
        check_frame(fb, 1'b0, 5'b11111, "R10");

        // R8: restart in mid-frame
        run_frame(16'h00F2, 1'b1, '1, 6);
        fb = 16'h9B6E;
        run_frame(fb, 1'b1, '1, FB);
        check_frame(fb, 1'b0, 5'b11111, "R8");

        // R7: lock handling
        fb = 16'h36D2;
        run_frame(fb, 1'b1, '0, FB);
        check_frame(fb, 1'b0, 5'b00000, "R7 unlocked");
        run_frame(fb, 1'b1, 16'hFFF0, FB);
        check_frame(fb, 1'b0, 5'b00000, "R7 late lock");
        run_frame(fb, 1'b1, '1, FB);
        check_frame(fb, 1'b0, 5'b11111, "R7 relocked");
        run_frame(fb, 1'b1, 16'h001F, FB);
        check_frame(fb, 1'b0, 5'b00011, "R7 lock lost");
        run_frame(fb, 1'b1, '1, FB);
        check_frame(fb, 1'b0, 5'b11111, "R7 recovered");

        // R4 and R7 together: enable form idles high without lock
        strobe_en_mode = 1'b1;
        run_frame(fb, 1'b1, '0, FB);
        check_frame(fb, 1'b1, 5'b00000, "R7 enable unlocked");

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule